// File: doc/BRIEF.md
# Nibble-Loaded Bank Register File

This block holds the bank selections for one operating mode of a cartridge bank controller. A CPU write port carries a 16-bit address and an 8-bit data byte. Before decoding, the register address is rebuilt from the upper address byte, with CPU address lines A3:A2 as the two lowest bits. All other low address lines are ignored. Eight character (CHR) bank registers are each filled four bits at a time, so one full bank number takes two writes. Two program (PRG) bank registers and a mirroring bit are loaded whole.

The outputs are combinational from the registers:
- four 8 KB PRG slot numbers, of which the last two are fixed to the final two pages;
- eight 1 KB CHR slot numbers;
- the mirroring mode.

All of these are raw numbers, before any outer masking. Writes that land on the interrupt timer group are only decoded, and leave the block as single-cycle strobes. A separate timer consumes those strobes.

Top module: `nib_bank_regs`

## Requirements
- R1: The rebuilt address is {wr_addr[15:8], 6'b0, wr_addr[3:2]}. CPU address lines A7:A4 and A1:A0 have no effect on which register is written.
- R2: Rebuilt addresses from 0xB000 to 0xE003 select CHR registers. With A11 clear, group 0xB/0xC/0xD/0xE and rebuilt offset 0–1 select register 0/2/4/6, and offset 2–3 selects register 1/3/5/7. CHR slot n (chr_slots[8n+7:8n]) shows CHR register n.
- R3: Rebuilt bit 0 clear writes wr_data[3:0] into bits 3:0 of the selected CHR register. Rebuilt bit 0 set writes wr_data[3:0] into bits 7:4. The other nibble is kept.
- R4: A write whose address has top nibble 0x8 loads the whole byte into PRG slot 0 (prg_slots[7:0]). A write with top nibble 0xA loads PRG slot 1 (prg_slots[15:8]).
- R5: A write with top nibble 0x9 loads mirror_horiz from wr_data[0]. The value 1 means horizontal mirroring and 0 means vertical.
- R6: PRG slot 2 (prg_slots[23:16]) is always 0xFE and PRG slot 3 (prg_slots[31:24]) is always 0xFF.
- R7: While wr_en is high, each of the rebuilt addresses 0xF000, 0xF001, 0xF002 and 0xF003 raises exactly one strobe. In that order they are stb_reload_lo, stb_reload_hi, stb_ctrl and stb_ack. No other write raises a strobe, and no strobe write changes any bank output.
- R8: After reset, CHR registers 0–3 hold 0xFF and CHR registers 4–7 hold 4, 5, 6 and 7. PRG slots 0 and 1 hold 0 and 1, and mirror_horiz is 0.
- R9: With wr_en low, no register changes and no strobe is raised, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to power-up values |
| wr_en | input | 1 | CPU write strobe for this mode, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_slots | output | 32 | Four 8-bit PRG page numbers, slot 0 in the low byte |
| chr_slots | output | 64 | Eight 8-bit CHR page numbers, slot 0 in the low byte |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| stb_reload_lo | output | 1 | Timer reload low-nibble write |
| stb_reload_hi | output | 1 | Timer reload high-nibble write |
| stb_ctrl | output | 1 | Timer control write |
| stb_ack | output | 1 | Timer acknowledge write |

## Verification
The hardest case to reach is keeping the untouched nibble. A CHR register only shows whether its other half survived after a second write to the opposite nibble with different data. The stimulus therefore fills the low nibble of all eight registers first. It then fills every high nibble with a distinct value, and then rewrites one register through an address with all the ignored low lines set. This shows that the address folding, the register index and the nibble merge each stay separate. Strobe addresses are also driven with junk in A1:A0 and with a nearby upper byte, which confirms the exact-match decode.

// File: rtl/nib_bank_regs.sv
module nib_bank_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic [31:0] prg_slots,
  output logic [63:0] chr_slots,
  output logic        mirror_horiz,
  output logic        stb_reload_lo,
  output logic        stb_reload_hi,
  output logic        stb_ctrl,
  output logic        stb_ack
);
  localparam logic [7:0] LAST_PAGE = 8'hFF;
  localparam logic [7:0] PREV_PAGE = 8'hFE;

  logic [15:0] ra;
  logic [15:0] idx_w;
  logic [2:0]  chr_idx;
  logic        chr_hit;
  logic [7:0]  chr_q [8];
  logic [7:0]  prg_q [2];
  logic        mir_q;

  assign ra      = {wr_addr[15:8], 6'd0, wr_addr[3:2]};
  assign chr_hit = (ra >= 16'hB000) && (ra <= 16'hE003);
  assign idx_w   = (((ra & 16'h0002) | (ra >> 10)) >> 1) + 16'd2;
  assign chr_idx = idx_w[2:0];

  logic unused_bits;
  assign unused_bits = ^{wr_addr[7:4], wr_addr[1:0], idx_w[15:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) chr_q[i] <= 8'hFF;
      for (int i = 4; i < 8; i++) chr_q[i] <= 8'(i);
      prg_q[0] <= 8'd0;
      prg_q[1] <= 8'd1;
      mir_q    <= 1'b0;
    end else if (wr_en) begin
      if (chr_hit) begin
        if (ra[0]) chr_q[chr_idx][7:4] <= wr_data[3:0];
        else       chr_q[chr_idx][3:0] <= wr_data[3:0];
      end else begin
        case (ra[15:12])
          4'h8: prg_q[0] <= wr_data;
          4'hA: prg_q[1] <= wr_data;
          4'h9: mir_q    <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  assign prg_slots     = {LAST_PAGE, PREV_PAGE, prg_q[1], prg_q[0]};
  assign mirror_horiz  = mir_q;
  assign stb_reload_lo = wr_en && (ra == 16'hF000);
  assign stb_reload_hi = wr_en && (ra == 16'hF001);
  assign stb_ctrl      = wr_en && (ra == 16'hF002);
  assign stb_ack       = wr_en && (ra == 16'hF003);

  for (genvar n = 0; n < 8; n++) begin : g_chr
    assign chr_slots[n*8 +: 8] = chr_q[n];

    p_low_nib_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && chr_hit && chr_idx == 3'(n) && !ra[0])
      |=> (chr_slots[n*8 +: 4] == $past(wr_data[3:0])) && $stable(chr_slots[n*8+4 +: 4]));

    p_high_nib_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && chr_hit && chr_idx == 3'(n) && ra[0])
      |=> (chr_slots[n*8+4 +: 4] == $past(wr_data[3:0])) && $stable(chr_slots[n*8 +: 4]));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(chr_slots[n*8 +: 8]));
  end

  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_ack, stb_ctrl, stb_reload_hi, stb_reload_lo}));

  p_prg0_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'h8) |=> prg_slots[7:0] == $past(wr_data));

  p_mirror_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[15:12] == 4'h9) |=> $stable(mirror_horiz));

  p_no_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(stb_ack || stb_ctrl || stb_reload_hi || stb_reload_lo));
endmodule

// File: tb/nib_bank_regs_tb.sv
module nib_bank_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [31:0] prg_slots;
  logic [63:0] chr_slots;
  logic        mirror_horiz;
  logic        stb_reload_lo, stb_reload_hi, stb_ctrl, stb_ack;

  always #4 clk = ~clk;

  nib_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_slots(prg_slots), .chr_slots(chr_slots), .mirror_horiz(mirror_horiz),
    .stb_reload_lo(stb_reload_lo), .stb_reload_hi(stb_reload_hi),
    .stb_ctrl(stb_ctrl), .stb_ack(stb_ack)
  );

  typedef struct {
    logic [31:0] prg;
    logic [63:0] chr;
    logic        mir;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  chr_m [8];
  logic [7:0]  prg_m [2];
  logic        mir_m;
  bit          done = 0;

  function automatic exp_t snap(string tag);
    exp_t e;
    e.prg = {8'hFF, 8'hFE, prg_m[1], prg_m[0]};
    for (int i = 0; i < 8; i++) e.chr[i*8 +: 8] = chr_m[i];
    e.mir = mir_m;
    e.tag = tag;
    return e;
  endfunction

  task automatic expect_state(string tag);
    q.push_back(snap(tag));
  endtask

  // strobe vector order: {ack, ctrl, reload_hi, reload_lo}
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en,
                    input logic [3:0] exp_stb, input string tag);
    logic [3:0] got;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    #1;
    got = {stb_ack, stb_ctrl, stb_reload_hi, stb_reload_lo};
    checks++;
    if (got !== exp_stb) begin
      errors++;
      $display("FAIL %s strobes addr=%h: got %b expected %b", tag, a, got, exp_stb);
    end
    @(posedge clk);
    #2;
    wr_en = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #4;
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (prg_slots !== e.prg || chr_slots !== e.chr || mirror_horiz !== e.mir) begin
          errors++;
          $display("FAIL %s: got prg=%h chr=%h mir=%b expected prg=%h chr=%h mir=%b",
                   e.tag, prg_slots, chr_slots, mirror_horiz, e.prg, e.chr, e.mir);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) chr_m[i] = 8'hFF;
    for (int i = 4; i < 8; i++) chr_m[i] = 8'(i);
    prg_m[0] = 8'd0; prg_m[1] = 8'd1; mir_m = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_state("R8 reset values R6 fixed slots");
    @(posedge clk); #6;

    // R2 R3: low nibbles of all eight registers
    for (int n = 0; n < 8; n++) begin
      logic [15:0] a;
      a = {4'(4'hB + n/2), 12'h000} | ((n % 2) ? 16'h0008 : 16'h0000);
      wr(a, {4'h5, 4'(n + 3)}, 1'b1, 4'b0000, "R2 chr low");
      chr_m[n][3:0] = 4'(n + 3);
      expect_state("R2 R3 low nibble, high kept");
    end
    // R3: high nibbles
    for (int n = 0; n < 8; n++) begin
      logic [15:0] a;
      a = {4'(4'hB + n/2), 12'h004} | ((n % 2) ? 16'h0008 : 16'h0000);
      wr(a, {4'h9, 4'(15 - n)}, 1'b1, 4'b0000, "R3 chr high");
      chr_m[n][7:4] = 4'(15 - n);
      expect_state("R3 high nibble, low kept");
    end

    // R1: A7:A4 and A1:A0 set, A3:A2 = 01 -> register 2 high nibble
    wr(16'hC0F7, 8'h0A, 1'b1, 4'b0000, "R1");
    chr_m[2][7:4] = 4'hA;
    expect_state("R1 ignored low lines");

    // R4
    wr(16'h8000, 8'h3C, 1'b1, 4'b0000, "R4");
    prg_m[0] = 8'h3C;
    expect_state("R4 prg slot 0");
    wr(16'hA123, 8'hC5, 1'b1, 4'b0000, "R4");
    prg_m[1] = 8'hC5;
    expect_state("R4 prg slot 1");

    // R5
    wr(16'h9000, 8'h01, 1'b1, 4'b0000, "R5");
    mir_m = 1'b1;
    expect_state("R5 horizontal");
    wr(16'h9003, 8'hFE, 1'b1, 4'b0000, "R5");
    mir_m = 1'b0;
    expect_state("R5 vertical");

    // R7 strobes, no state change
    wr(16'hF000, 8'hFF, 1'b1, 4'b0001, "R7 reload lo");
    wr(16'hF004, 8'hFF, 1'b1, 4'b0010, "R7 reload hi");
    wr(16'hF008, 8'hFF, 1'b1, 4'b0100, "R7 ctrl");
    wr(16'hF00C, 8'hFF, 1'b1, 4'b1000, "R7 ack");
    wr(16'hF003, 8'hFF, 1'b1, 4'b0001, "R7 A1A0 ignored");
    wr(16'hF100, 8'hFF, 1'b1, 4'b0000, "R7 no strobe");
    expect_state("R7 strobes leave banks unchanged");

    // R9: disabled writes
    wr(16'h8000, 8'h77, 1'b0, 4'b0000, "R9 prg");
    wr(16'hB004, 8'h0E, 1'b0, 4'b0000, "R9 chr");
    wr(16'h9000, 8'h01, 1'b0, 4'b0000, "R9 mir");
    wr(16'hF000, 8'h00, 1'b0, 4'b0000, "R9 strobe");
    expect_state("R9 nothing changed");

    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule